// File: doc/BRIEF.md
# Multi-Cycle Multiply-Accumulate Unit

This block is the multiply and multiply-accumulate engine of a 32-bit processor core. The core presents two 32-bit operands, a 2-bit operation code, a signedness select and a one-cycle start strobe. The unit computes a product and either writes it into a 64-bit accumulator or adds it there. The accumulator is read as a high and a low 32-bit half.

Each of the four operations has its own fixed latency. The 16x16 multiply finishes in one cycle. The 16x16 accumulate and the 32x32 multiply each take two cycles. The 32x32 accumulate takes three cycles. A busy/done handshake reports progress, and the core can zero the accumulator at any time with a one-cycle clear.

Top module: `mac_unit`

## Requirements
- R1: op_i = 2'b00 (16x16 multiply) forms the product of opa_i[15:0] and opb_i[15:0], writes its low 32 bits to acc_lo_o, and leaves acc_hi_o unchanged. done_o rises on the 1st rising edge after the edge that accepted the start.
- R2: op_i = 2'b01 (16x16 accumulate) adds the 16x16 product, extended to 64 bits, to the 64-bit accumulator. done_o rises on the 2nd edge after acceptance.
- R3: op_i = 2'b10 (32x32 multiply) writes the full 64-bit product, high word to acc_hi_o and low word to acc_lo_o. done_o rises on the 2nd edge after acceptance.
- R4: op_i = 2'b11 (32x32 accumulate) adds the 64-bit product to the accumulator. done_o rises on the 3rd edge after acceptance.
- R5: signed_i = 1 treats both operands as two's complement and signed_i = 0 treats them as unsigned. In the 16-bit operations, operand bits 31:16 have no effect.
- R6: busy_o goes high on the edge that accepts a start and stays high until the edge where done_o rises. At that edge busy_o falls. done_o is a one-cycle pulse and is never high together with busy_o.
- R7: A start_i asserted while busy_o is high is ignored. The running operation keeps its own operands, operation code and latency.
- R8: clr_i zeroes both accumulator halves on the next edge. If a result write-back falls on the same edge, the clear wins and done_o still pulses.
- R9: Accumulation wraps modulo 2^64 with no saturation. An accumulate adds to the accumulator value present at its write-back edge, which includes any clear applied while it was running.
- R10: The accumulator changes only on an edge where done_o rises or on the edge after clr_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while idle |
| op_i | input | 2 | Operation: 00 mul16, 01 mac16, 10 mul32, 11 mac32 |
| signed_i | input | 1 | 1 = signed operands, 0 = unsigned |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| clr_i | input | 1 | Zero the accumulator |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| acc_hi_o | output | 32 | Accumulator bits 63:32 |
| acc_lo_o | output | 32 | Accumulator bits 31:0 |

## Verification
The interesting collision is a clear that lands on the same edge as a result write-back. The bench starts a 32x32 multiply and raises clr_i so that it is sampled exactly on the completion edge. It then expects done_o to pulse with both halves reading zero. A second case raises the clear one edge into a 32x32 accumulate. The final value must then equal the bare product, which shows that the sum is formed from the accumulator as it stands at write-back.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_MUL16 = 2'b00,
    OP_MAC16 = 2'b01,
    OP_MUL32 = 2'b10,
    OP_MAC32 = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_operand_ext.sv
module mac_operand_ext #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = 16
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic              wide_i,
  input  logic              signed_i,
  output logic [DATA_W:0]   ext_o
);
  localparam int unsigned PAD_W = DATA_W - HALF_W + 1;

  always_comb begin
    if (wide_i) ext_o = {signed_i & val_i[DATA_W-1], val_i};
    else        ext_o = {{PAD_W{signed_i & val_i[HALF_W-1]}}, val_i[HALF_W-1:0]};
  end
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ACC_W = 2 * DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DATA_W:0]  a_i,
  input  logic [DATA_W:0]  b_i,
  output logic [ACC_W-1:0] prod_o
);
  logic [ACC_W-1:0] prod_d;

  // both operands carry an explicit extension bit, so a signed multiply covers both modes
  assign prod_d = ACC_W'($signed(a_i) * $signed(b_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prod_o <= '0;
    else if (load_i) prod_o <= prod_d;
  end
endmodule

// File: rtl/mac_seq.sv
module mac_seq
  import mac_pkg::*;
#(
  parameter int unsigned LAT_MUL16 = 1,
  parameter int unsigned LAT_MAC16 = 2,
  parameter int unsigned LAT_MUL32 = 2,
  parameter int unsigned LAT_MAC32 = 3
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  mac_op_e op_i,
  output logic    load_o,
  output logic    busy_o,
  output logic    wb_o,
  output mac_op_e op_o
);
  localparam int unsigned MAX_A   = (LAT_MUL16 > LAT_MAC16) ? LAT_MUL16 : LAT_MAC16;
  localparam int unsigned MAX_B   = (LAT_MUL32 > LAT_MAC32) ? LAT_MUL32 : LAT_MAC32;
  localparam int unsigned LAT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W   = (LAT_MAX > 1) ? $clog2(LAT_MAX) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  mac_op_e          op_q;

  function automatic logic [CNT_W-1:0] cycles_left(mac_op_e op);
    case (op)
      OP_MUL16: return CNT_W'(LAT_MUL16 - 1);
      OP_MAC16: return CNT_W'(LAT_MAC16 - 1);
      OP_MUL32: return CNT_W'(LAT_MUL32 - 1);
      default:  return CNT_W'(LAT_MAC32 - 1);
    endcase
  endfunction

  assign load_o = start_i & ~busy_q;
  assign wb_o   = busy_q & (cnt_q == '0);
  assign busy_o = busy_q;
  assign op_o   = op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_MUL16;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= cycles_left(op_i);
      op_q   <= op_i;
    end else if (wb_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/mac_acc.sv
module mac_acc
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ACC_W = 2 * DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wb_i,
  input  mac_op_e          op_i,
  input  logic [ACC_W-1:0] prod_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;              // clear beats a coincident write-back
    end else if (wb_i) begin
      case (op_i)
        OP_MUL16: acc_q[DATA_W-1:0] <= prod_i[DATA_W-1:0];
        OP_MUL32: acc_q             <= prod_i;
        default:  acc_q             <= acc_q + prod_i;
      endcase
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned LAT_MUL16 = 1,
  parameter int unsigned LAT_MAC16 = 2,
  parameter int unsigned LAT_MUL32 = 2,
  parameter int unsigned LAT_MAC32 = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              clr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] acc_hi_o,
  output logic [DATA_W-1:0] acc_lo_o
);
  localparam int unsigned ACC_W = 2 * DATA_W;
  localparam int unsigned N_OPS = 2;

  mac_op_e          op_in, op_run;
  logic             load, wb, wide;
  logic [DATA_W-1:0] opnd [N_OPS];
  logic [DATA_W:0]   ext  [N_OPS];
  logic [ACC_W-1:0]  prod, acc;
  logic              done_q;

  assign op_in   = mac_op_e'(op_i);
  assign wide    = (op_in == OP_MUL32) || (op_in == OP_MAC32);
  assign opnd[0] = opa_i;
  assign opnd[1] = opb_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_ext
    mac_operand_ext #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_ext (
      .val_i    (opnd[g]),
      .wide_i   (wide),
      .signed_i (signed_i),
      .ext_o    (ext[g])
    );
  end

  mac_seq #(
    .LAT_MUL16(LAT_MUL16), .LAT_MAC16(LAT_MAC16),
    .LAT_MUL32(LAT_MUL32), .LAT_MAC32(LAT_MAC32)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_i    (op_in),
    .load_o  (load),
    .busy_o  (busy_o),
    .wb_o    (wb),
    .op_o    (op_run)
  );

  mac_mult #(.DATA_W(DATA_W)) u_mult (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .a_i    (ext[0]),
    .b_i    (ext[1]),
    .prod_o (prod)
  );

  mac_acc #(.DATA_W(DATA_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .wb_i   (wb),
    .op_i   (op_run),
    .prod_i (prod),
    .acc_o  (acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= wb;
  end

  assign done_o   = done_q;
  assign acc_hi_o = acc[ACC_W-1:DATA_W];
  assign acc_lo_o = acc[DATA_W-1:0];
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LAT_MUL16 = 1,
  parameter int unsigned LAT_MAC16 = 2,
  parameter int unsigned LAT_MUL32 = 2,
  parameter int unsigned LAT_MAC32 = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [1:0]        op_i,
  input logic              clr_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] acc_hi_o,
  input logic [DATA_W-1:0] acc_lo_o
);
  logic [1:0] seen_op;
  logic [7:0] seen_cnt;

  // independent view of the handshake: latch the op at acceptance, count busy cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_op  <= 2'b00;
      seen_cnt <= '0;
    end else if (start_i && !busy_o) begin
      seen_op  <= op_i;
      seen_cnt <= '0;
    end else if (busy_o && seen_cnt != 8'hFF) begin
      seen_cnt <= seen_cnt + 1'b1;
    end
  end

  AST_LAT_MUL16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && seen_op == OP_MUL16) |-> seen_cnt == 8'(LAT_MUL16)); // R1
  AST_LAT_MAC16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && seen_op == OP_MAC16) |-> seen_cnt == 8'(LAT_MAC16)); // R2
  AST_LAT_MUL32: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && seen_op == OP_MUL32) |-> seen_cnt == 8'(LAT_MUL32)); // R3
  AST_LAT_MAC32: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && seen_op == OP_MAC32) |-> seen_cnt == 8'(LAT_MAC32)); // R4
  AST_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && seen_op == OP_MUL16 && !$past(clr_i)) |-> $stable(acc_hi_o)); // R1
  AST_BUSY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R6
  AST_NO_BUSY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_hi_o == '0 && acc_lo_o == '0)); // R8
  AST_ACC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !$past(clr_i)) |-> ($stable(acc_hi_o) && $stable(acc_lo_o))); // R10
endmodule

bind mac_unit mac_unit_chk #(
  .DATA_W(DATA_W), .LAT_MUL16(LAT_MUL16), .LAT_MAC16(LAT_MAC16),
  .LAT_MUL32(LAT_MUL32), .LAT_MAC32(LAT_MAC32)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .op_i     (op_i),
  .clr_i    (clr_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .acc_hi_o (acc_hi_o),
  .acc_lo_o (acc_lo_o)
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        signed_i = 1'b0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        clr_i = 1'b0;
  logic        busy_o, done_o;
  logic [31:0] acc_hi_o, acc_lo_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [63:0] model = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mac_unit u0 (
    .clk_i, .rst_ni, .start_i, .op_i, .signed_i, .opa_i, .opb_i, .clr_i,
    .busy_o, .done_o, .acc_hi_o, .acc_lo_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(input logic [1:0] op, input logic sgn,
                                           input logic [31:0] a, input logic [31:0] b);
    logic [63:0] x, y;
    if (op[1]) begin
      x = sgn ? {{32{a[31]}}, a} : {32'b0, a};
      y = sgn ? {{32{b[31]}}, b} : {32'b0, b};
    end else begin
      x = sgn ? {{48{a[15]}}, a[15:0]} : {48'b0, a[15:0]};
      y = sgn ? {{48{b[15]}}, b[15:0]} : {48'b0, b[15:0]};
    end
    return x * y;
  endfunction

  task automatic model_op(input logic [1:0] op, input logic sgn, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p;
    p = ref_prod(op, sgn, a, b);
    case (op)
      2'b00:   model[31:0] = p[31:0];
      2'b10:   model = p;
      default: model = model + p;
    endcase
  endtask

  task automatic run_op(input logic [1:0] op, input logic sgn, input logic [31:0] a,
                        input logic [31:0] b, output int lat);
    op_i = op; signed_i = sgn; opa_i = a; opb_i = b; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 20) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic do_op(input string req, input logic [1:0] op, input logic sgn,
                       input logic [31:0] a, input logic [31:0] b, input int exp_lat);
    int lat;
    run_op(op, sgn, a, b, lat);
    model_op(op, sgn, a, b);
    chk({req, " latency"}, 64'(lat), 64'(exp_lat));
    chk({req, " result"}, {acc_hi_o, acc_lo_o}, model);
    @(negedge clk_i);
    chk({req, " done pulse/busy idle"}, {62'b0, done_o, busy_o}, 64'b0);
  endtask

  task automatic do_clear();
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    model = '0;
  endtask

  task automatic t_reset();
    chk("R6 reset busy/done", {62'b0, busy_o, done_o}, 64'b0);
    chk("R10 reset accumulator", {acc_hi_o, acc_lo_o}, 64'b0);
  endtask

  task automatic t_mul16();
    do_op("R3 mul32 preset", 2'b10, 1'b0, 32'hDEAD_BEEF, 32'h1357_9BDF, 2);
    do_op("R1 R5 mul16 signed", 2'b00, 1'b1, 32'hABCD_8000, 32'h1234_FFFF, 1);
    chk("R1 hi unchanged", {32'b0, acc_hi_o}, {32'b0, model[63:32]});
    do_op("R1 R5 mul16 unsigned", 2'b00, 1'b0, 32'h5555_8000, 32'h0000_FFFF, 1);
    chk("R5 mul16 unsigned value", {32'b0, acc_lo_o}, 64'h7FFF_8000);
  endtask

  task automatic t_mac16();
    do_clear();
    do_op("R2 mac16 signed", 2'b01, 1'b1, 32'h0000_FFFE, 32'hFFFF_0003, 2);
    chk("R2 R5 mac16 negative sum", {acc_hi_o, acc_lo_o}, 64'hFFFF_FFFF_FFFF_FFFA);
    do_op("R2 mac16 unsigned", 2'b01, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF, 2);
  endtask

  task automatic t_mul32();
    do_op("R3 R5 mul32 signed", 2'b10, 1'b1, 32'hFFFF_FFFE, 32'h0000_0003, 2);
    chk("R3 signed value", {acc_hi_o, acc_lo_o}, 64'hFFFF_FFFF_FFFF_FFFA);
    do_op("R3 R5 mul32 unsigned", 2'b10, 1'b0, 32'hFFFF_FFFE, 32'h0000_0003, 2);
    chk("R3 unsigned value", {acc_hi_o, acc_lo_o}, 64'h0000_0002_FFFF_FFFA);
  endtask

  task automatic t_mac32_wrap();
    do_clear();
    do_op("R3 mul32 max", 2'b10, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2);
    do_op("R4 R9 mac32 wrap", 2'b11, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3);
    chk("R9 wrapped value", {acc_hi_o, acc_lo_o}, 64'hFFFF_FFFC_0000_0002);
    do_op("R4 mac32 signed", 2'b11, 1'b1, 32'h8000_0000, 32'h0000_0002, 3);
  endtask

  task automatic t_busy_ignore();
    int lat;
    op_i = 2'b11; signed_i = 1'b0; opa_i = 32'h0001_0000; opb_i = 32'h0000_0010; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; lat = 0;
    @(negedge clk_i); lat++;
    op_i = 2'b00; opa_i = 32'h0000_7777; opb_i = 32'h0000_0002; start_i = 1'b1;
    @(negedge clk_i); lat++;
    start_i = 1'b0;
    while (!done_o && lat < 20) begin
      @(negedge clk_i);
      lat++;
    end
    model_op(2'b11, 1'b0, 32'h0001_0000, 32'h0000_0010);
    chk("R7 latency kept", 64'(lat), 64'd3);
    chk("R7 first op result", {acc_hi_o, acc_lo_o}, model);
    @(negedge clk_i);
    chk("R7 no restart", {62'b0, busy_o, done_o}, 64'b0);
  endtask

  task automatic t_clear();
    do_op("R3 mul32 nonzero", 2'b10, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 2);
    do_clear();
    chk("R8 idle clear", {acc_hi_o, acc_lo_o}, 64'b0);
    do_op("R3 mul32 refill", 2'b10, 1'b0, 32'h0000_1111, 32'h0002_0000, 2);
    // clear sampled on the completion edge of a mul32
    op_i = 2'b10; signed_i = 1'b0; opa_i = 32'hFFFF_0000; opb_i = 32'h0000_FFFF; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    model = '0;
    chk("R8 done with coincident clear", {63'b0, done_o}, 64'b1);
    chk("R8 clear wins", {acc_hi_o, acc_lo_o}, 64'b0);
    @(negedge clk_i);
    do_op("R3 mul32 refill2", 2'b10, 1'b0, 32'h0000_0033, 32'h0000_0100, 2);
    // clear in the middle of a mac32
    begin
      int lat;
      op_i = 2'b11; signed_i = 1'b0; opa_i = 32'h0000_0005; opb_i = 32'h0000_0007; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0; clr_i = 1'b1; lat = 0;
      @(negedge clk_i); lat++;
      clr_i = 1'b0;
      while (!done_o && lat < 20) begin
        @(negedge clk_i);
        lat++;
      end
      chk("R9 mac32 after mid clear latency", 64'(lat), 64'd3);
      chk("R9 mac32 adds onto cleared acc", {acc_hi_o, acc_lo_o}, 64'd35);
      model = 64'd35;
    end
    @(negedge clk_i);
  endtask

  task automatic t_quiet();
    logic [63:0] snap;
    snap = {acc_hi_o, acc_lo_o};
    for (int i = 0; i < 6; i++) begin
      opa_i = 32'hA5A5_0000 ^ 32'(i); opb_i = ~opa_i; op_i = 2'(i); signed_i = i[0];
      @(negedge clk_i);
    end
    chk("R10 idle accumulator stable", {acc_hi_o, acc_lo_o}, snap);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mul16();
    t_mac16();
    t_mul32();
    t_mac32_wrap();
    t_busy_ignore();
    t_clear();
    t_quiet();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule